// File: doc/BRIEF.md
# Banked GPIO Interrupt Detector

This block watches banks of general-purpose input pins (four banks of 32 pins by default) and turns activity on them into latched interrupt events. For each pin, software chooses whether it is level-sensitive or edge-triggered. It also chooses the active level or edge direction and, in edge mode only, whether both edges count. Every pin is first brought into the clock domain through a two-flop synchronizer. Its events are then latched into a per-pin status bit.

All pins of all banks drive a single interrupt line. That line is high whenever any latched status bit belongs to a pin that is not masked. To find the source, software reads each bank's mask view and status word. Masking works through two write-only registers: writing ones to one of them unmasks pins, and writing ones to the other masks them. A read-only register shows the resulting mask. Status bits are cleared by writing ones to them.

A simple word-addressed register port reaches every register. The address is split as {bank, select}, where the bank index is the upper bits and the 3-bit select is the lower bits. The select codes are: 0 mask view, 1 unmask, 2 mask, 3 status, 4 type, 5 polarity, 6 any-edge. Read data is combinational.

Top module: `gpio_irq_detect`

## Requirements
- R1: A pin change becomes visible to detection only after two synchronizing clocks: a level made active before clock edge k sets its status bit at edge k+2, and irq_o (if unmasked) is high after that edge and not before.
- R2: Select 0 reads the bank's mask word (1 = masked) and ignores writes; selects 1, 2 and 7 read as zero.
- R3: Writing to select 1 clears the mask bit of every pin whose data bit is 1; data bits of 0 leave the mask unchanged.
- R4: Writing to select 2 sets the mask bit of every pin whose data bit is 1; data bits of 0 leave the mask unchanged.
- R5: Writing to select 3 clears every status bit whose data bit is 1, unless a new event on that pin arrives in the same cycle; data bits of 0 have no effect. Status bits latch events whether or not the pin is masked.
- R6: With type bit 0 (level mode), a status bit is set on every cycle the synchronized pin equals its polarity bit (1 = high, 0 = low), so a clear has no lasting effect while the level persists.
- R7: With type bit 1 (edge mode) and any-edge bit 0, a status bit is set by a rising edge when polarity is 1 and by a falling edge when polarity is 0.
- R8: With type bit 1 and any-edge bit 1, both edges set the status bit; in level mode the any-edge bit has no effect.
- R9: irq_o is the OR over all banks and pins of (status AND NOT mask).
- R10: After reset every pin is masked, type, polarity and any-edge words are zero, all status bits are zero and irq_o is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| gpio_i | input | NUM_BANKS*PINS | Asynchronous pin inputs, bank 0 in the low bits |
| reg_we_i | input | 1 | Register write strobe |
| reg_addr_i | input | ADDR_W | Word address {bank, select} |
| reg_wdata_i | input | PINS | Register write data |
| reg_rdata_o | output | PINS | Register read data for reg_addr_i |
| irq_o | output | 1 | Shared interrupt output |

## Verification
The bench checks the synchronizer latency cycle by cycle. A design with one flop too few or too many raises irq_o one clock early or late. It re-clears a status bit while a level is still held: a design that treats level mode like edge mode would let the bit and the interrupt drop. It sets the any-edge bit in level mode, where a design that decodes it regardless would latch falling edges as events. It writes zero bits to the unmask, mask and clear registers and writes to the read-only mask view: a design that loads whole words would corrupt unrelated pins.

// File: rtl/gpio_irq_pkg.sv
package gpio_irq_pkg;
  typedef enum logic [2:0] {
    SEL_MASK  = 3'd0,
    SEL_UNMSK = 3'd1,
    SEL_MSK   = 3'd2,
    SEL_STAT  = 3'd3,
    SEL_TYPE  = 3'd4,
    SEL_POL   = 3'd5,
    SEL_ANY   = 3'd6,
    SEL_RSVD  = 3'd7
  } reg_sel_e;
endpackage

// File: rtl/gpio_sync.sv
module gpio_sync #(
  parameter int W = 32
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] meta_q, sync_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      meta_q <= '0;
      sync_q <= '0;
    end else begin
      meta_q <= d_i;
      sync_q <= meta_q;
    end
  end

  assign q_o = sync_q;
endmodule

// File: rtl/gpio_event.sv
module gpio_event #(
  parameter int W = 32
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] pin_i,
  input  logic [W-1:0] type_i,
  input  logic [W-1:0] pol_i,
  input  logic [W-1:0] any_i,
  output logic [W-1:0] ev_o
);
  logic [W-1:0] prev_q, rise, fall, edge_ev, lvl_ev;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) prev_q <= '0;
    else         prev_q <= pin_i;
  end

  assign rise    = pin_i & ~prev_q;
  assign fall    = ~pin_i & prev_q;
  // any-edge overrides direction; meaningful only under edge type
  assign edge_ev = (any_i & (rise | fall)) |
                   (~any_i & ((pol_i & rise) | (~pol_i & fall)));
  assign lvl_ev  = ~(pin_i ^ pol_i);
  assign ev_o    = (type_i & edge_ev) | (~type_i & lvl_ev);
endmodule

// File: rtl/gpio_bank.sv
module gpio_bank
  import gpio_irq_pkg::*;
#(
  parameter int PINS = 32
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic [PINS-1:0] pin_i,
  input  logic            wr_i,
  input  reg_sel_e        sel_i,
  input  logic [PINS-1:0] wdata_i,
  output logic [PINS-1:0] mask_o,
  output logic [PINS-1:0] status_o,
  output logic [PINS-1:0] type_o,
  output logic [PINS-1:0] pol_o,
  output logic [PINS-1:0] any_o,
  output logic            irq_o
);
  logic [PINS-1:0] mask_q, status_q, type_q, pol_q, any_q;
  logic [PINS-1:0] pin_s, ev, unmsk_wr, msk_wr, clr_wr;

  gpio_sync #(.W(PINS)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (pin_i),
    .q_o   (pin_s)
  );

  gpio_event #(.W(PINS)) u_event (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .pin_i (pin_s),
    .type_i(type_q),
    .pol_i (pol_q),
    .any_i (any_q),
    .ev_o  (ev)
  );

  assign unmsk_wr = (wr_i && sel_i == SEL_UNMSK) ? wdata_i : '0;
  assign msk_wr   = (wr_i && sel_i == SEL_MSK)   ? wdata_i : '0;
  assign clr_wr   = (wr_i && sel_i == SEL_STAT)  ? wdata_i : '0;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mask_q   <= '1;
      status_q <= '0;
      type_q   <= '0;
      pol_q    <= '0;
      any_q    <= '0;
    end else begin
      mask_q   <= (mask_q & ~unmsk_wr) | msk_wr;
      // new event wins over a same-cycle clear
      status_q <= (status_q & ~clr_wr) | ev;
      if (wr_i && sel_i == SEL_TYPE) type_q <= wdata_i;
      if (wr_i && sel_i == SEL_POL)  pol_q  <= wdata_i;
      if (wr_i && sel_i == SEL_ANY)  any_q  <= wdata_i;
    end
  end

  assign mask_o   = mask_q;
  assign status_o = status_q;
  assign type_o   = type_q;
  assign pol_o    = pol_q;
  assign any_o    = any_q;
  assign irq_o    = |(status_q & ~mask_q);

  p_unmask_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|unmsk_wr) |=> ((mask_q & $past(unmsk_wr)) == '0));

  p_mask_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|msk_wr) |=> ((mask_q & $past(msk_wr)) == $past(msk_wr)));

  p_clear_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|(clr_wr & ~ev)) |=> ((status_q & $past(clr_wr & ~ev)) == '0));

  p_event_sets_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|ev) |=> ((status_q & $past(ev)) == $past(ev)));

  p_all_masked_quiet_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (&mask_q) |-> !irq_o);
endmodule

// File: rtl/gpio_irq_detect.sv
module gpio_irq_detect
  import gpio_irq_pkg::*;
#(
  parameter int NUM_BANKS = 4,
  parameter int PINS      = 32,
  parameter int ADDR_W    = 5
) (
  input  logic                      clk_i,
  input  logic                      rst_ni,
  input  logic [NUM_BANKS*PINS-1:0] gpio_i,
  input  logic                      reg_we_i,
  input  logic [ADDR_W-1:0]         reg_addr_i,
  input  logic [PINS-1:0]           reg_wdata_i,
  output logic [PINS-1:0]           reg_rdata_o,
  output logic                      irq_o
);
  localparam int SEL_W  = 3;
  localparam int BANK_W = ADDR_W - SEL_W;

  reg_sel_e          sel;
  logic [BANK_W-1:0] bank_idx;
  logic [PINS-1:0]   bank_rd [NUM_BANKS];
  logic [NUM_BANKS-1:0] bank_irq;

  assign sel      = reg_sel_e'(reg_addr_i[SEL_W-1:0]);
  assign bank_idx = reg_addr_i[ADDR_W-1:SEL_W];

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
    logic [PINS-1:0] mask, status, typ, pol, any;
    logic            hit;

    assign hit = (bank_idx == BANK_W'(b));

    gpio_bank #(.PINS(PINS)) u_bank (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .pin_i   (gpio_i[b*PINS +: PINS]),
      .wr_i    (reg_we_i && hit),
      .sel_i   (sel),
      .wdata_i (reg_wdata_i),
      .mask_o  (mask),
      .status_o(status),
      .type_o  (typ),
      .pol_o   (pol),
      .any_o   (any),
      .irq_o   (bank_irq[b])
    );

    always_comb begin
      unique case (sel)
        SEL_MASK: bank_rd[b] = mask;
        SEL_STAT: bank_rd[b] = status;
        SEL_TYPE: bank_rd[b] = typ;
        SEL_POL:  bank_rd[b] = pol;
        SEL_ANY:  bank_rd[b] = any;
        default:  bank_rd[b] = '0;
      endcase
    end
  end

  always_comb begin
    reg_rdata_o = '0;
    for (int b = 0; b < NUM_BANKS; b++)
      if (bank_idx == BANK_W'(b)) reg_rdata_o = bank_rd[b];
  end

  assign irq_o = |bank_irq;

  p_reset_quiet_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(rst_ni) |-> !irq_o);
endmodule

// File: tb/tb_gpio_irq_detect.sv
`timescale 1ns/1ps
module tb_gpio_irq_detect;
  localparam int NB = 4;
  localparam int NP = 32;

  logic           clk = 0;
  logic           rst_n = 0;
  logic [NB*NP-1:0] gpio = '0;
  logic           we = 0;
  logic [4:0]     addr = '0;
  logic [NP-1:0]  wdata = '0;
  logic [NP-1:0]  rdata;
  logic           irq;

  int n_chk = 0, n_fail = 0;
  bit started = 0;

  gpio_irq_detect dut (
    .clk_i(clk), .rst_ni(rst_n), .gpio_i(gpio), .reg_we_i(we),
    .reg_addr_i(addr), .reg_wdata_i(wdata), .reg_rdata_o(rdata), .irq_o(irq)
  );

  always #2.5 clk = ~clk;

  // reference model state
  logic [NP-1:0] m_s1[NB], m_s2[NB], m_pv[NB], m_st[NB], m_mk[NB], m_ty[NB], m_po[NB], m_an[NB];

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int b = 0; b < NB; b++) begin
        m_s1[b] = '0; m_s2[b] = '0; m_pv[b] = '0; m_st[b] = '0;
        m_mk[b] = '1; m_ty[b] = '0; m_po[b] = '0; m_an[b] = '0;
      end
    end else begin
      for (int b = 0; b < NB; b++) begin
        bit hit;
        int s;
        logic [NP-1:0] ev;
        hit = we && (int'(addr[4:3]) == b);
        s = int'(addr[2:0]);
        for (int p = 0; p < NP; p++) begin
          bit cur, old, r, f;
          cur = m_s2[b][p]; old = m_pv[b][p];
          r = cur && !old; f = !cur && old;
          if (m_ty[b][p]) ev[p] = m_an[b][p] ? (r || f) : (m_po[b][p] ? r : f);
          else            ev[p] = (cur == m_po[b][p]);
        end
        if (hit && s == 3) m_st[b] = m_st[b] & ~wdata;
        m_st[b] = m_st[b] | ev;
        if (hit && s == 1) m_mk[b] = m_mk[b] & ~wdata;
        if (hit && s == 2) m_mk[b] = m_mk[b] | wdata;
        if (hit && s == 4) m_ty[b] = wdata;
        if (hit && s == 5) m_po[b] = wdata;
        if (hit && s == 6) m_an[b] = wdata;
        m_pv[b] = m_s2[b]; m_s2[b] = m_s1[b]; m_s1[b] = gpio[b*NP +: NP];
      end
    end
  end

  function automatic logic m_irq();
    logic r = 0;
    for (int b = 0; b < NB; b++) r |= |(m_st[b] & ~m_mk[b]);
    return r;
  endfunction

  function automatic logic [NP-1:0] m_read(int b, int s);
    case (s)
      0: return m_mk[b];
      3: return m_st[b];
      4: return m_ty[b];
      5: return m_po[b];
      6: return m_an[b];
      default: return '0;
    endcase
  endfunction

  task automatic chk(bit ok, string req, logic [NP-1:0] act, logic [NP-1:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h at %0t", req, act, exp, $time);
    end
  endtask

  always @(negedge clk)
    if (rst_n && started) chk(irq === m_irq(), "R9 irq", {31'b0, irq}, {31'b0, m_irq()});

  task automatic wr(int b, int s, logic [NP-1:0] d);
    @(negedge clk);
    we = 1; addr = {b[1:0], s[2:0]}; wdata = d;
    @(negedge clk);
    we = 0; wdata = '0;
  endtask

  task automatic rd(int b, int s, string req);
    @(negedge clk);
    addr = {b[1:0], s[2:0]};
    #1;
    chk(rdata === m_read(b, s), req, rdata, m_read(b, s));
  endtask

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic set_pin(int b, int p, bit v);
    @(negedge clk);
    gpio[b*NP + p] = v;
  endtask

  initial begin
    #200000;
    n_fail++; n_chk++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    // R10 reset state
    #12;
    addr = 5'd0; #1;
    chk(rdata === '1, "R10 mask reset", rdata, '1);
    addr = {2'd2, 3'd4}; #1;
    chk(rdata === '0, "R10 type reset", rdata, '0);
    addr = {2'd1, 3'd3}; #1;
    chk(rdata === '0, "R10 status reset", rdata, '0);
    chk(irq === 1'b0, "R10 irq reset", {31'b0, irq}, '0);
    @(negedge clk); rst_n = 1; started = 1;
    idle(4);
    // R6 level low with pins low sets status immediately
    rd(0, 3, "R6 level-low status");
    for (int b = 0; b < NB; b++) wr(b, 5, '1);  // level high everywhere
    for (int b = 0; b < NB; b++) wr(b, 3, '1);
    rd(0, 3, "R5 w1c all");
    rd(3, 3, "R5 w1c bank3");
    // R2 read-only mask view, reserved selects read zero
    wr(0, 0, '0);
    rd(0, 0, "R2 mask write ignored");
    rd(0, 1, "R2 unmask reads zero");
    rd(0, 7, "R2 reserved reads zero");
    // R3 unmask, zero bits no effect
    wr(0, 1, 32'h8);
    rd(0, 0, "R3 unmask pin3");
    wr(0, 1, 32'h0);
    rd(0, 0, "R3 zero write no effect");
    // R1 latency: pin set at negedge, irq after 3rd posedge
    set_pin(0, 3, 1);
    @(posedge clk); @(posedge clk); #1;
    chk(irq === 1'b0, "R1 not before two sync stages", {31'b0, irq}, '0);
    @(posedge clk); #1;
    chk(irq === 1'b1, "R1 irq at third edge", {31'b0, irq}, 32'h1);
    // R6 clear while level held has no lasting effect
    wr(0, 3, 32'h8);
    rd(0, 3, "R6 level persists");
    set_pin(0, 3, 0); idle(3);
    wr(0, 3, 32'h8);
    rd(0, 3, "R6 cleared after level gone");
    // R5 status latches while masked
    set_pin(0, 5, 1); idle(4);
    rd(0, 3, "R5 latched while masked");
    set_pin(0, 5, 0); idle(3);
    wr(0, 3, 32'h0);
    rd(0, 3, "R5 zero clear no effect");
    wr(0, 3, '1);
    // R4 mask
    wr(0, 2, 32'h8);
    rd(0, 0, "R4 mask pin3");
    // R7 edge modes on bank1
    wr(1, 4, '1); wr(1, 5, 32'h0000_FFFF); wr(1, 3, '1); wr(1, 1, '1);
    rd(1, 3, "R7 clean start");
    set_pin(1, 0, 1); set_pin(1, 20, 1); idle(4);
    rd(1, 3, "R7 rising on pol1 only");
    wr(1, 3, '1);
    set_pin(1, 0, 0); set_pin(1, 20, 0); idle(4);
    rd(1, 3, "R7 falling on pol0 only");
    wr(1, 3, '1);
    // R8 both edges
    wr(1, 6, 32'h1);
    set_pin(1, 0, 1); idle(4);
    rd(1, 3, "R8 any rising");
    wr(1, 3, '1);
    set_pin(1, 0, 0); idle(4);
    rd(1, 3, "R8 any falling");
    wr(1, 3, '1);
    // R8 any-edge ignored in level mode (bank2 level high)
    wr(2, 6, '1); wr(2, 1, '1);
    set_pin(2, 7, 1); idle(3);
    set_pin(2, 7, 0); idle(3);
    wr(2, 3, '1); idle(4);
    rd(2, 3, "R8 level ignores any on fall");
    // randomized mix
    for (int i = 0; i < 400; i++) begin
      @(negedge clk);
      gpio = {$urandom, $urandom, $urandom, $urandom};
      if ($urandom_range(0, 3) == 0)
        wr($urandom_range(0, 3), $urandom_range(1, 6), $urandom);
    end
    for (int b = 0; b < NB; b++) begin
      rd(b, 3, "R5 random status");
      rd(b, 0, "R3 random mask");
      rd(b, 4, "R7 random type");
      rd(b, 6, "R8 random any");
    end
    idle(2);
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule